// File: doc/BRIEF.md
# Half-Bridge Fault Protection Supervisor

This block is the digital fault manager that sits beside a half-bridge gate driver. It takes synchronized comparator flags from the analog front end. These cover the main supply, the logic supply and the charge-pump supply, the drain-source voltage of each FET, the current-sense pin, the gate level of each FET and two die-temperature comparators. From these it decides, cycle by cycle, whether the high-side FET, the low-side FET, the charge pump and the internal regulator may run. It also drives an active-low fault output.

Each fault class recovers in its own way. Supply, charge-pump and overtemperature faults follow their condition: overtemperature uses a separate cooled-down flag for hysteresis. Overcurrent and gate-drive faults hold the bridge off for a fixed retry window and then try again. A logic-supply collapse wipes every piece of internal state.

A five-bit status word records every fault class that has occurred. Its bits stay set after the fault output has released, until a one-cycle clear pulse arrives. The deglitch, retry and gate-timeout lengths are parameters counted in clock cycles.

Top module: `hb_fault_supervisor`

## Requirements
- R1: While `uv_supply_i` is high, `hs_en_o`, `ls_en_o` and `pump_en_o` are low and `fault_n_o` is low in the same cycle, and `reg_en_o` stays high. When the flag drops, the commanded FETs re-enable in the same cycle.
- R2: While `uv_logic_i` is high, all four enables and `fault_n_o` are low. After the first clock edge with the flag high, the status word, any running retry window and the overtemperature latch are all cleared.
- R3: While `uv_pump_i` is high, both FET enables and `fault_n_o` are low but `pump_en_o` stays high. Operation resumes in the same cycle the flag drops.
- R4: An overcurrent event occurs when the drain-source flag of a FET whose enable output is high stays high for DEGLITCH_CYC+1 consecutive cycles. A low cycle before that restarts the count. The flag of a FET that is not enabled has no effect.
- R5: After an overcurrent or gate-drive event, both FET enables are low and `fault_n_o` is low for exactly RETRY_CYC cycles, starting on the cycle after the event. Drive then resumes, and the window repeats if the condition returns.
- R6: A high `ocp_sense_i` is an overcurrent event in the same cycle, with no deglitch.
- R7: A gate-drive event occurs when a FET's gate-level flag differs from that FET's enable output for DRIVE_CYC+1 consecutive cycles.
- R8: A high `ot_hot_i` turns off both FETs, the pump and the regulator in the same cycle. All four stay off, with `fault_n_o` low, until a cycle in which `ot_cool_i` is high and `ot_hot_i` is low.
- R9: Status bit positions, counted from the LSB, are: 0 overtemperature, 1 charge-pump undervoltage, 2 supply undervoltage, 3 gate-drive fault, 4 overcurrent. A bit is set on the clock edge that ends a cycle in which its condition or event is present. It stays set after the condition ends.
- R10: A high `clr_flt_i` for one cycle clears the status word on the next edge. A bit whose condition is present in that same cycle is set anyway.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_supply_i | input | 1 | Main supply below lockout threshold |
| uv_logic_i | input | 1 | Supply below logic-reset threshold |
| uv_pump_i | input | 1 | Charge-pump voltage below threshold |
| hs_cmd_i | input | 1 | High-side FET commanded on |
| ls_cmd_i | input | 1 | Low-side FET commanded on |
| vds_hs_i | input | 1 | High-side drain-source overcurrent comparator |
| vds_ls_i | input | 1 | Low-side drain-source overcurrent comparator |
| ocp_sense_i | input | 1 | Sense-pin overcurrent comparator |
| gate_hs_i | input | 1 | High-side gate level is high |
| gate_ls_i | input | 1 | Low-side gate level is high |
| ot_hot_i | input | 1 | Die above shutdown temperature |
| ot_cool_i | input | 1 | Die below shutdown temperature minus hysteresis |
| clr_flt_i | input | 1 | One-cycle status clear pulse |
| hs_en_o | output | 1 | High-side FET enable |
| ls_en_o | output | 1 | Low-side FET enable |
| pump_en_o | output | 1 | Charge-pump enable |
| reg_en_o | output | 1 | Regulator enable |
| fault_n_o | output | 1 | Active-low fault output |
| status_o | output | 5 | Sticky fault status word |

## Verification
The hardest situation to reach from the ports is a fault that persists through retry: the overcurrent or stuck gate stays present, so the bridge cycles between a fixed off window and a re-armed deglitch or timeout count. The bench holds a drain-source flag high, or pins a gate-level flag, for several full periods. It compares the fault output in every cycle against a period computed from the parameters. Deglitch boundaries are swept by pulse length around the threshold, and the clear pulse is applied both with and without an active condition.

// File: rtl/hbfs_pkg.sv
package hbfs_pkg;
   localparam int unsigned NSTAT = 5;
   localparam int unsigned ST_OT   = 0;
   localparam int unsigned ST_CPUV = 1;
   localparam int unsigned ST_SUV  = 2;
   localparam int unsigned ST_GDF  = 3;
   localparam int unsigned ST_OCP  = 4;
   localparam int unsigned NFET = 2;
   typedef logic [NSTAT-1:0] stat_t;
endpackage

// File: rtl/hbfs_persist.sv
module hbfs_persist #(
   parameter int unsigned LIMIT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_clr,
   input  logic level_i,
   output logic hit_o
);
   localparam int unsigned W = $clog2(LIMIT + 1);
   localparam logic [W-1:0] LIM = W'(LIMIT);

   logic [W-1:0] cnt;

   assign hit_o = level_i && (cnt == LIM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (sync_clr || !level_i || hit_o) cnt <= '0;
      else                        cnt <= cnt + 1'b1;
   end

   // R4 / R7: a hit needs the level to have been high on the previous cycle too
   assert_hit_needs_history_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> $past(level_i));
endmodule

// File: rtl/hbfs_retry.sv
module hbfs_retry #(
   parameter int unsigned RETRY = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_clr,
   input  logic load_i,
   output logic busy_o
);
   localparam int unsigned W = $clog2(RETRY + 1);
   localparam logic [W-1:0] RLD = W'(RETRY);

   logic [W-1:0] cnt;

   assign busy_o = (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (sync_clr)   cnt <= '0;
      else if (load_i)     cnt <= RLD;
      else if (busy_o)     cnt <= cnt - 1'b1;
   end

   assert_load_starts_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !sync_clr) |=> busy_o);
   assert_window_only_from_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(load_i));
endmodule

// File: rtl/hbfs_status.sv
module hbfs_status
   import hbfs_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wipe_i,
   input  logic  clr_i,
   input  stat_t set_i,
   output stat_t status_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      status_o <= '0;
      else if (wipe_i) status_o <= '0;
      else if (clr_i)  status_o <= set_i;
      else             status_o <= status_o | set_i;
   end

   assert_set_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wipe_i |=> ((status_o & $past(set_i)) == $past(set_i)));
   assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wipe_i && !clr_i) |=> ((status_o & $past(status_o)) == $past(status_o)));
endmodule

// File: rtl/hb_fault_supervisor.sv
module hb_fault_supervisor
   import hbfs_pkg::*;
#(
   parameter int unsigned DEGLITCH_CYC = 3,
   parameter int unsigned RETRY_CYC    = 5,
   parameter int unsigned DRIVE_CYC    = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       uv_supply_i,
   input  logic       uv_logic_i,
   input  logic       uv_pump_i,
   input  logic       hs_cmd_i,
   input  logic       ls_cmd_i,
   input  logic       vds_hs_i,
   input  logic       vds_ls_i,
   input  logic       ocp_sense_i,
   input  logic       gate_hs_i,
   input  logic       gate_ls_i,
   input  logic       ot_hot_i,
   input  logic       ot_cool_i,
   input  logic       clr_flt_i,
   output logic       hs_en_o,
   output logic       ls_en_o,
   output logic       pump_en_o,
   output logic       reg_en_o,
   output logic       fault_n_o,
   output logic [4:0] status_o
);
   if (DEGLITCH_CYC < 1) begin : g_bad_deglitch
      $error("DEGLITCH_CYC must be at least 1");
   end
   if (RETRY_CYC < 1) begin : g_bad_retry
      $error("RETRY_CYC must be at least 1");
   end
   if (DRIVE_CYC < 1) begin : g_bad_drive
      $error("DRIVE_CYC must be at least 1");
   end

   logic            ot_lat, ot_active, retry_busy, fets_ok;
   logic            ocp_evt, gdf_evt;
   logic [NFET-1:0] fet_cmd, fet_en, vds, gate_lvl, ocp_hit, gdf_hit;
   stat_t           set_vec;

   assign fet_cmd  = {ls_cmd_i, hs_cmd_i};
   assign vds      = {vds_ls_i, vds_hs_i};
   assign gate_lvl = {gate_ls_i, gate_hs_i};

   assign ot_active = ot_lat || ot_hot_i;
   assign fets_ok   = !uv_logic_i && !uv_supply_i && !uv_pump_i && !ot_active && !retry_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     ot_lat <= 1'b0;
      else if (uv_logic_i)            ot_lat <= 1'b0;
      else if (ot_hot_i)              ot_lat <= 1'b1;
      else if (ot_cool_i)             ot_lat <= 1'b0;
   end

   for (genvar i = 0; i < NFET; i++) begin : g_fet
      assign fet_en[i] = fet_cmd[i] && fets_ok;

      hbfs_persist #(.LIMIT(DEGLITCH_CYC)) u_ocp (
         .clk(clk), .rst_n(rst_n), .sync_clr(uv_logic_i),
         .level_i(vds[i] && fet_en[i]), .hit_o(ocp_hit[i]));

      hbfs_persist #(.LIMIT(DRIVE_CYC)) u_gdt (
         .clk(clk), .rst_n(rst_n), .sync_clr(uv_logic_i),
         .level_i(gate_lvl[i] != fet_en[i]), .hit_o(gdf_hit[i]));
   end

   assign ocp_evt = !uv_logic_i && ((|ocp_hit) || ocp_sense_i);
   assign gdf_evt = !uv_logic_i && (|gdf_hit);

   hbfs_retry #(.RETRY(RETRY_CYC)) u_retry (
      .clk(clk), .rst_n(rst_n), .sync_clr(uv_logic_i),
      .load_i(ocp_evt || gdf_evt), .busy_o(retry_busy));

   always_comb begin
      set_vec          = '0;
      set_vec[ST_OT]   = ot_hot_i;
      set_vec[ST_CPUV] = uv_pump_i;
      set_vec[ST_SUV]  = uv_supply_i;
      set_vec[ST_GDF]  = gdf_evt;
      set_vec[ST_OCP]  = ocp_evt;
   end

   hbfs_status u_stat (
      .clk(clk), .rst_n(rst_n), .wipe_i(uv_logic_i), .clr_i(clr_flt_i),
      .set_i(set_vec), .status_o(status_o));

   assign hs_en_o   = fet_en[0];
   assign ls_en_o   = fet_en[1];
   assign pump_en_o = !uv_logic_i && !uv_supply_i && !ot_active;
   assign reg_en_o  = !uv_logic_i && !ot_active;
   assign fault_n_o = !(uv_logic_i || uv_supply_i || uv_pump_i || ot_active || retry_busy);

   assert_drive_implies_no_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_en_o || ls_en_o) |-> fault_n_o);
   assert_ot_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_en_o && !uv_logic_i && !ot_cool_i) |=> !reg_en_o);
   assert_wipe_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
      uv_logic_i |=> (status_o == '0));
endmodule

// File: tb/sim_hb_fault_supervisor.sv
module sim_hb_fault_supervisor;
   localparam int CLK_PERIOD = 10;
   localparam int DG = 3;
   localparam int RT = 5;
   localparam int DR = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic uv_supply = 0, uv_logic = 0, uv_pump = 0, hs_cmd = 0, ls_cmd = 0;
   logic vds_hs = 0, vds_ls = 0, sense = 0, ot_hot = 0, ot_cool = 0, clr = 0;
   logic hs_stuck = 0, hs_stuck_val = 0;
   logic gate_hs, gate_ls;
   logic hs_en, ls_en, pump_en, reg_en, fault_n;
   logic [4:0] status;
   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign gate_hs = hs_stuck ? hs_stuck_val : hs_en;
   assign gate_ls = ls_en;

   hb_fault_supervisor #(.DEGLITCH_CYC(DG), .RETRY_CYC(RT), .DRIVE_CYC(DR)) u0 (
      .clk(clk), .rst_n(rst_n), .uv_supply_i(uv_supply), .uv_logic_i(uv_logic),
      .uv_pump_i(uv_pump), .hs_cmd_i(hs_cmd), .ls_cmd_i(ls_cmd), .vds_hs_i(vds_hs),
      .vds_ls_i(vds_ls), .ocp_sense_i(sense), .gate_hs_i(gate_hs), .gate_ls_i(gate_ls),
      .ot_hot_i(ot_hot), .ot_cool_i(ot_cool), .clr_flt_i(clr), .hs_en_o(hs_en),
      .ls_en_o(ls_en), .pump_en_o(pump_en), .reg_en_o(reg_en), .fault_n_o(fault_n),
      .status_o(status));

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic clear_status();
      clr = 1; tick(); clr = 0;
   endtask

   // outputs packed as {hs,ls,pump,reg,fault_n}
   function automatic int outs();
      return {27'd0, hs_en, ls_en, pump_en, reg_en, fault_n};
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1; tick();
      chk("R9 reset status", status, 0);
      chk("R1 reset outputs", outs(), 5'b00111);
      hs_cmd = 1; settle();
      chk("R1 drive on", outs(), 5'b10111);

      // R1 supply undervoltage
      uv_supply = 1; settle();
      chk("R1 supply UV outputs", outs(), 5'b00010);
      tick();
      chk("R9 supply UV bit2", status, 5'b00100);
      uv_supply = 0; settle();
      chk("R1 supply UV resume", outs(), 5'b10111);
      tick();
      chk("R9 sticky after release", status, 5'b00100);
      clear_status();
      chk("R10 clear", status, 0);
      uv_supply = 1; clr = 1; tick(); clr = 0;
      chk("R10 clear with active condition", status, 5'b00100);
      uv_supply = 0; clear_status();

      // R3 pump undervoltage
      uv_pump = 1; settle();
      chk("R3 pump UV outputs", outs(), 5'b00110);
      tick();
      chk("R3 pump UV bit1", status, 5'b00010);
      uv_pump = 0; settle();
      chk("R3 pump UV resume", outs(), 5'b10111);
      clear_status();

      // R4 deglitch length sweep
      for (int n = 1; n <= 6; n++) begin
         vds_hs = 1; repeat (n) tick(); vds_hs = 0; settle();
         chk($sformatf("R4 ocp bit after %0d high cycles", n), int'(status[4]), (n >= DG + 1) ? 1 : 0);
         chk($sformatf("R5 fault after %0d high cycles", n), int'(fault_n), (n >= DG + 1) ? 0 : 1);
         repeat (RT + 1) tick();
         clear_status();
      end
      // R4 restart on a low cycle
      vds_hs = 1; repeat (DG) tick(); vds_hs = 0; tick();
      vds_hs = 1; repeat (DG) tick(); vds_hs = 0; settle();
      chk("R4 restart no event", int'(status[4]), 0);
      // R4 undriven FET ignored
      ls_cmd = 0; vds_ls = 1; repeat (10) tick(); vds_ls = 0;
      chk("R4 undriven ignored status", status, 0);
      chk("R4 undriven ignored fault", int'(fault_n), 1);

      // R6 sense + R5 retry window
      sense = 1; tick(); sense = 0;
      chk("R6 sense sets bit4", status, 5'b10000);
      for (int k = 1; k <= RT + 1; k++) begin
         chk($sformatf("R5 retry window tick %0d", k), int'(fault_n), (k <= RT) ? 0 : 1);
         chk($sformatf("R5 fet during tick %0d", k), int'(hs_en), (k <= RT) ? 0 : 1);
         if (k <= RT) tick();
      end
      clear_status();

      // R5 repeating retry with persistent overcurrent
      vds_hs = 1;
      for (int i = 1; i <= 3 * (DG + 1 + RT); i++) begin
         settle();
         chk($sformatf("R5 repeat interval %0d", i), int'(fault_n),
             (((i - 1) % (DG + 1 + RT)) < DG + 1) ? 1 : 0);
         tick();
      end
      vds_hs = 0; repeat (RT + 1) tick(); clear_status();

      // R7 gate stuck low while commanded on
      hs_stuck = 1; hs_stuck_val = 0;
      for (int i = 1; i <= 2 * (DR + 1 + RT); i++) begin
         settle();
         chk($sformatf("R7 gate timeout interval %0d", i), int'(fault_n),
             (((i - 1) % (DR + 1 + RT)) < DR + 1) ? 1 : 0);
         tick();
      end
      chk("R7 gdf bit3", int'(status[3]), 1);
      chk("R7 no ocp bit", int'(status[4]), 0);
      hs_stuck = 0; repeat (RT + 1) tick(); clear_status();

      // R8 overtemperature with hysteresis
      ot_hot = 1; settle();
      chk("R8 hot outputs", outs(), 5'b00000);
      tick(); ot_hot = 0; settle();
      chk("R8 hold until cool", outs(), 5'b00000);
      repeat (4) tick();
      chk("R8 still held", outs(), 5'b00000);
      chk("R9 ot bit0", status, 5'b00001);
      ot_cool = 1; tick(); ot_cool = 0;
      chk("R8 resume after cool", outs(), 5'b10111);
      clear_status();

      // R2 logic undervoltage wipes status and retry
      uv_supply = 1; uv_pump = 1; tick(); uv_supply = 0; uv_pump = 0;
      sense = 1; tick(); sense = 0;
      chk("R9 combined bits", status, 5'b10110);
      uv_logic = 1; settle();
      chk("R2 logic UV outputs", outs(), 5'b00000);
      tick();
      chk("R2 status wiped", status, 0);
      uv_logic = 0; settle();
      chk("R2 retry cleared", outs(), 5'b10111);
      ot_hot = 1; tick(); ot_hot = 0; uv_logic = 1; tick(); uv_logic = 0; settle();
      chk("R2 ot latch cleared", outs(), 5'b10111);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule